// File: doc/BRIEF.md
# Burst Data Port for a Single-Bank Synchronous DRAM Model

This block is the device side of a synchronous DRAM data path, reduced to one bank and backed by a small on-chip array. A controller drives a command code plus row and column addresses on each rising clock edge. It opens a row, then reads or writes bursts of 16-bit words in that row. The port runs the burst address sequence itself, so the controller supplies only the first column.

Read data returns after a selectable column latency of two or three clocks, and a single output-enable marks the cycles in which the port drives the data bus. Write data is taken with no latency, starting on the command edge. Two byte-mask bits hide individual bytes. On writes a mask acts in the same cycle. On reads it acts one cycle later, so that it lines up with the receiver's sampling edge two clocks after the mask was sampled. Bursts of 1, 2, 4 or 8 words end by themselves. A full-row burst runs until a stop command.

Top module: `sdram_burst_port`

## Requirements
- R1: While reset is asserted and after it is released with no command given, `dq_oe_o` is 0, `dq_o` is 0, `err_o` is 0 and the bank is idle.
- R2: Command codes are 0 no-op, 1 open row, 2 read, 3 write, 4 burst stop and 5 close bank; codes 6 and 7 act as no-op. Code 1 opens the row on `row_i` and code 5 returns the bank to idle. A read or write given while the bank is idle changes no stored data and drives no bus cycle. It sets `err_o`, which then stays 1 until reset.
- R3: A write stores the word on `dq_i` at the command edge to the column on `col_i`, and takes the following words on consecutive edges. With `blen_i` codes 0, 1, 2 and 3 the burst is 1, 2, 4 or 8 words and then ends by itself; codes 4 to 6 behave as code 0.
- R4: Word i of a burst of length L that starts at column s goes to column (s − s mod L) + ((s mod L + i) mod L). With `blen_i` code 7 (full row), L is the row size of 16 columns, so the sequence wraps from column 15 to column 0.
- R5: For a read sampled at edge n, word j is driven on `dq_o` from edge n+CL−1+j until edge n+CL+j, where it is sampled, with CL = 3 when `cas3_i` is 1 and CL = 2 otherwise.
- R6: `dq_oe_o` goes to 1 at edge n+CL−1 of a read and goes back to 0 by itself at the edge after the last word has been sampled. Outside driven cycles `dq_o` is 0.
- R7: A full-row burst, read or write, continues until a burst stop. A stop issues no word on its own edge. Read words issued before the stop still come out, and after them `dq_oe_o` falls.
- R8: On writes, `dqm_i` bit 1 guards bits 15:8 and bit 0 guards bits 7:0. A guarded byte keeps its old contents for the word taken on that same edge.
- R9: On reads, a `dqm_i` bit sampled at edge k forces its byte of `dq_o` to 0 in the word sampled at edge k+2.
- R10: Any command other than a no-op or an ignored one ends the running burst. A read or write then starts a new burst at once. A write also discards every read word still waiting, so `dq_oe_o` is 0 after the write edge and for the rest of the write burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| row_i | input | ROW_W | Row to open with the open-row command |
| col_i | input | COL_W | First column of a read or write burst |
| blen_i | input | 3 | Burst length code, sampled with read or write |
| cas3_i | input | 1 | 1 selects read latency 3, 0 selects latency 2 |
| dqm_i | input | 2 | Byte masks, bit 1 upper byte, bit 0 lower byte |
| dq_i | input | 16 | Write data from the bus |
| dq_o | output | 16 | Read data toward the bus |
| dq_oe_o | output | 1 | High while the port drives the bus |
| err_o | output | 1 | Sticky flag for read or write to an idle bank |

## Verification
Two functions can meet in the same clock. One is the draining of read words already in the latency pipeline. The other is a new command that starts, cuts or flushes a burst, or a byte mask that lands on one of those draining words. The bench provokes this by issuing reads, writes, stops and row opens in the middle of running bursts at both latencies, with mask patterns that change every cycle. A behavioural model keeps a queue of pending read words, each tagged with its due edge. On every clock it predicts the enable, the masked data and the error flag, and the model's values are compared with the port's outputs.

// File: rtl/sdram_port_pkg.sv
package sdram_port_pkg;
  localparam int DQ_W  = 16;
  localparam int NBYTE = DQ_W / 8;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_STOP = 3'd4,
    CMD_PRE  = 3'd5
  } cmd_e;

  // Number of words a burst-length code asks for; code 7 is one whole row.
  function automatic logic [31:0] burst_words(input logic [2:0] code, input int unsigned col_w);
    if (code == 3'd7) return 32'd1 << col_w;
    if (code[2]) return 32'd1;
    return 32'd1 << code[1:0];
  endfunction

  // Column of word idx: wraps inside the len-aligned block that holds start.
  function automatic logic [31:0] burst_col(input logic [31:0] start, input logic [31:0] idx,
                                            input logic [31:0] len);
    return (start & ~(len - 32'd1)) | ((start + idx) & (len - 32'd1));
  endfunction

  // Per byte: hold bit set keeps 'keep', clear takes 'fresh'.
  function automatic logic [DQ_W-1:0] byte_merge(input logic [DQ_W-1:0] keep,
                                                 input logic [DQ_W-1:0] fresh,
                                                 input logic [NBYTE-1:0] hold);
    logic [DQ_W-1:0] r;
    for (int b = 0; b < NBYTE; b++)
      r[b*8 +: 8] = hold[b] ? keep[b*8 +: 8] : fresh[b*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/sdram_cmd_ctl.sv
module sdram_cmd_ctl
  import sdram_port_pkg::*;
#(
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROW_W-1:0] open_row_o,
  output logic             go_rd_o,
  output logic             go_wr_o,
  output logic             term_o,
  output logic             err_o
);
  cmd_e cmd;
  logic bank_open;
  logic rw_req;
  logic idle_hit;

  assign cmd      = cmd_e'(cmd_i);
  assign rw_req   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign idle_hit = rw_req && !bank_open;
  assign go_rd_o  = (cmd == CMD_RD) && bank_open;
  assign go_wr_o  = (cmd == CMD_WR) && bank_open;
  assign term_o   = (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_STOP, CMD_PRE}) && !idle_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_open  <= 1'b0;
      open_row_o <= '0;
      err_o      <= 1'b0;
    end else begin
      if (idle_hit) err_o <= 1'b1;
      if (cmd == CMD_ACT) begin
        bank_open  <= 1'b1;
        open_row_o <= row_i;
      end else if (cmd == CMD_PRE) begin
        bank_open <= 1'b0;
      end
    end
  end

  // R2: the error flag never clears without reset
  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> err_o);
  // R2: read or write to an idle bank raises the flag
  p_idle_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd2 || cmd_i == 3'd3) && !bank_open) |=> err_o);
  // R2: an ignored command starts nothing
  p_idle_no_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |-> !(go_rd_o || go_wr_o));
endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
  import sdram_port_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_rd_i,
  input  logic             go_wr_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       blen_i,
  output logic             iss_rd_o,
  output logic             iss_wr_o,
  output logic [COL_W-1:0] iss_col_o
);
  localparam int LEN_W = COL_W + 1;
  localparam logic [LEN_W-1:0] PAGE = LEN_W'(32'd1 << COL_W);

  logic             busy, cur_rd;
  logic [COL_W-1:0] start, idx;
  logic [LEN_W-1:0] len, req_len;
  logic             new_cmd, cont, last;

  assign new_cmd  = go_rd_i || go_wr_i;
  assign cont     = busy && !term_i;
  assign req_len  = LEN_W'(burst_words(blen_i, COL_W));
  assign last     = (len != PAGE) && ({1'b0, idx} == len - LEN_W'(1));
  assign iss_rd_o = go_rd_i || (cont && cur_rd);
  assign iss_wr_o = go_wr_i || (cont && !cur_rd);
  assign iss_col_o = new_cmd ? col_i
                   : COL_W'(burst_col(32'(start), 32'(idx), 32'(len)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_rd <= 1'b0;
      start  <= '0;
      idx    <= '0;
      len    <= LEN_W'(1);
    end else if (new_cmd) begin
      busy   <= (req_len != LEN_W'(1));
      cur_rd <= go_rd_i;
      start  <= col_i;
      len    <= req_len;
      idx    <= COL_W'(1);
    end else if (term_i) begin
      busy <= 1'b0;
    end else if (busy) begin
      idx <= idx + COL_W'(1);
      if (last) busy <= 1'b0;
    end
  end

  // R3: a one-word burst leaves nothing running
  p_single_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cmd && req_len == LEN_W'(1)) |=> !busy);
  // R7: a stop ends the burst
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !new_cmd) |=> !busy);
  // R4: a fixed-length burst never indexes past its length
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && len != PAGE) |-> ({1'b0, idx} < len));
  // R10: at most one word is issued per clock
  p_one_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_rd_o && iss_wr_o));
endmodule

// File: rtl/sdram_word_array.sv
module sdram_word_array
  import sdram_port_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [DQ_W-1:0]  wdata_i,
  input  logic [NBYTE-1:0] wmask_i,
  output logic [DQ_W-1:0]  rdata_o
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DQ_W-1:0]   mem [DEPTH];
  logic [ADDR_W-1:0] addr;

  assign addr    = {row_i, col_i};
  assign rdata_o = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[addr] <= byte_merge(mem[addr], wdata_i, wmask_i);
    end
  end
endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe
  import sdram_port_pkg::*;
#(
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_rd_i,
  input  logic             flush_i,
  input  logic [DQ_W-1:0]  rdata_i,
  input  logic             cas3_i,
  input  logic [NBYTE-1:0] dqm_i,
  output logic [DQ_W-1:0]  dq_o,
  output logic             oe_o
);
  localparam int TAP_LONG  = MAX_CL - 1;
  localparam int TAP_SHORT = MAX_CL - 2;

  logic [MAX_CL-1:0]           vld;
  logic [MAX_CL-1:0][DQ_W-1:0] dat;
  logic [NBYTE-1:0]            qm1, qm2;
  logic                        out_v;
  logic [DQ_W-1:0]             out_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      dat <= '0;
      qm1 <= '0;
      qm2 <= '0;
    end else begin
      vld[0] <= iss_rd_i && !flush_i;
      dat[0] <= rdata_i;
      for (int s = 1; s < MAX_CL; s++) begin
        vld[s] <= vld[s-1] && !flush_i;
        dat[s] <= dat[s-1];
      end
      qm1 <= dqm_i;
      qm2 <= qm1;
    end
  end

  assign out_v = cas3_i ? vld[TAP_LONG] : vld[TAP_SHORT];
  assign out_d = cas3_i ? dat[TAP_LONG] : dat[TAP_SHORT];
  assign oe_o  = out_v;
  assign dq_o  = out_v ? byte_merge('0, out_d, qm2) : '0;

  // R10: a write drops every waiting read word
  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) flush_i |=> !oe_o);
  // R6: the bus is not driven before anything was issued
  p_oe_needs_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0 && !iss_rd_i) |=> !vld[0]);
endmodule

// File: rtl/sdram_burst_port.sv
module sdram_burst_port
  import sdram_port_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       blen_i,
  input  logic             cas3_i,
  input  logic [1:0]       dqm_i,
  input  logic [15:0]      dq_i,
  output logic [15:0]      dq_o,
  output logic             dq_oe_o,
  output logic             err_o
);
  logic [ROW_W-1:0] open_row;
  logic             go_rd, go_wr, term;
  logic             iss_rd, iss_wr;
  logic [COL_W-1:0] iss_col;
  logic [DQ_W-1:0]  rdata;

  sdram_cmd_ctl #(.ROW_W(ROW_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .row_i(row_i),
    .open_row_o(open_row), .go_rd_o(go_rd), .go_wr_o(go_wr),
    .term_o(term), .err_o(err_o)
  );

  sdram_burst_gen #(.COL_W(COL_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .go_rd_i(go_rd), .go_wr_i(go_wr), .term_i(term),
    .col_i(col_i), .blen_i(blen_i),
    .iss_rd_o(iss_rd), .iss_wr_o(iss_wr), .iss_col_o(iss_col)
  );

  sdram_word_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(iss_wr), .row_i(open_row), .col_i(iss_col),
    .wdata_i(dq_i), .wmask_i(dqm_i), .rdata_o(rdata)
  );

  sdram_read_pipe #(.MAX_CL(3)) u_rpipe (
    .clk(clk), .rst_n(rst_n), .iss_rd_i(iss_rd), .flush_i(go_wr), .rdata_i(rdata),
    .cas3_i(cas3_i), .dqm_i(dqm_i), .dq_o(dq_o), .oe_o(dq_oe_o)
  );

  // R10: the bus stays released while a write burst continues
  p_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_wr && !go_wr) |-> !dq_oe_o);
endmodule

// File: tb/sdram_burst_port_test.sv
module sdram_burst_port_test;
  localparam int CLK_NS = 10;
  localparam int ROW_W = 2;
  localparam int COL_W = 4;
  localparam int COLS  = 1 << COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [ROW_W-1:0] row = '0;
  logic [COL_W-1:0] col = '0;
  logic [2:0] blen = 3'd0;
  logic cas3 = 1'b0;
  logic [1:0] dqm = 2'b00;
  logic [15:0] dq_in = 16'h0;
  logic [15:0] dq_out;
  logic oe, err;

  always #(CLK_NS/2) clk = ~clk;

  sdram_burst_port #(.ROW_W(ROW_W), .COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .row_i(row), .col_i(col), .blen_i(blen),
    .cas3_i(cas3), .dqm_i(dqm), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(oe), .err_o(err)
  );

  int vectors = 0, misses = 0;
  string tag = "R1";

  // behavioural reference state
  logic [15:0] mmem [64];
  bit mopen = 0, merr = 0, bon = 0, brd = 0;
  int mrow = 0, bstart = 0, bidx = 0, blenw = 1, edge_n = 0;
  int qdue[$];
  logic [15:0] qword[$];
  logic [1:0] dqm_prev = 2'b00, mask_now = 2'b00;

  function automatic int words_of(logic [2:0] c);
    if (c == 3'd7) return COLS;
    if (c > 3'd3) return 1;
    return 1 << c;
  endfunction

  function automatic int seq_col(int s, int i, int l);
    return (s - (s % l)) + (((s % l) + i) % l);
  endfunction

  function automatic logic [15:0] lanes(logic [15:0] old, logic [15:0] nw, logic [1:0] hold);
    logic [15:0] r;
    r = nw;
    if (hold[0]) r[7:0] = old[7:0];
    if (hold[1]) r[15:8] = old[15:8];
    return r;
  endfunction

  task automatic model_edge();
    bit rw, ign, trm, iss, isr;
    int a;
    iss = 0; isr = 0; a = 0;
    edge_n++;
    mask_now = dqm_prev;
    dqm_prev = dqm;
    while (qdue.size() > 0 && qdue[0] < edge_n) begin
      void'(qdue.pop_front());
      void'(qword.pop_front());
    end
    rw  = (cmd == 3'd2 || cmd == 3'd3);
    ign = rw && !mopen;
    if (ign) merr = 1;
    trm = (cmd >= 3'd1 && cmd <= 3'd5) && !ign;
    if (rw && !ign) begin
      brd = (cmd == 3'd2); bstart = int'(col); blenw = words_of(blen); bidx = 0; bon = 1;
    end else if (trm) begin
      bon = 0;
    end
    if (bon) begin
      a = seq_col(bstart, bidx, blenw);
      iss = 1; isr = brd; bidx++;
      if (blenw != COLS && bidx == blenw) bon = 0;
    end
    if (rw && !ign && cmd == 3'd3) begin
      qdue.delete();
      qword.delete();
    end
    if (iss) begin
      if (isr) begin
        qdue.push_back(edge_n + (cas3 ? 3 : 2) - 1);
        qword.push_back(mmem[mrow*COLS + a]);
      end else begin
        mmem[mrow*COLS + a] = lanes(mmem[mrow*COLS + a], dq_in, dqm);
      end
    end
    if (cmd == 3'd1) begin mopen = 1; mrow = int'(row); end
    else if (cmd == 3'd5) mopen = 0;
  endtask

  task automatic check(string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s at edge %0d: got %h expected %h", tag, what, edge_n, act, exp);
    end
  endtask

  task automatic compare();
    bit eo;
    logic [15:0] ed;
    eo = (qdue.size() > 0 && qdue[0] == edge_n);
    ed = eo ? lanes(16'h0000, qword[0], mask_now) : 16'h0000;
    check("dq_oe_o", {15'd0, oe}, {15'd0, eo});
    check("dq_o", dq_out, ed);
    check("err_o", {15'd0, err}, {15'd0, merr});
  endtask

  task automatic step(logic [2:0] c, int cl, logic [15:0] d, logic [1:0] m);
    cmd = c; col = COL_W'(cl); dq_in = d; dqm = m;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(3'd0, 0, 16'h0, 2'b00);
  endtask

  // command on the first cycle, then no-ops; data and masks change every cycle
  task automatic burst(logic [2:0] c, int cl, int n, logic [15:0] base, logic [31:0] mpat);
    for (int i = 0; i < n; i++)
      step(i == 0 ? c : 3'd0, cl, base + 16'(i * 37), 2'((mpat >> (2*i)) & 32'h3));
  endtask

  task automatic open_row(int r);
    row = ROW_W'(r);
    step(3'd1, 0, 16'h0, 2'b00);
  endtask

  initial begin
    #(CLK_NS * 100000);
    misses++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mmem[i] = 16'h0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("reset oe", {15'd0, oe}, 16'd0);
    check("reset dq", dq_out, 16'd0);
    check("reset err", {15'd0, err}, 16'd0);
    rst_n = 1'b1;
    idle(2);

    // R2: read and write to an idle bank are ignored and flag an error
    tag = "R2";
    blen = 3'd2;
    burst(3'd3, 4, 4, 16'h5A5A, 0);
    burst(3'd2, 4, 5, 16'h0, 0);

    // R3 and R4: write bursts of each fixed length, starting mid-block
    tag = "R3";
    open_row(1);
    blen = 3'd2; burst(3'd3, 5, 4, 16'h1100, 0);
    blen = 3'd0; burst(3'd3, 9, 2, 16'h2200, 0);
    blen = 3'd1; burst(3'd3, 11, 3, 16'h3300, 0);
    blen = 3'd3; burst(3'd3, 3, 9, 16'h4400, 0);
    blen = 3'd5; burst(3'd3, 13, 2, 16'h6600, 0);

    // R4, R5, R6: read everything back at latency 2 and latency 3
    tag = "R5";
    blen = 3'd3; cas3 = 1'b0; burst(3'd2, 6, 12, 16'h0, 0);
    tag = "R6";
    blen = 3'd2; cas3 = 1'b1; burst(3'd2, 7, 8, 16'h0, 0);
    tag = "R4";
    blen = 3'd3; burst(3'd2, 13, 12, 16'h0, 0);

    // R7: full-row write wrapping past column 15, then full-row read with stop
    tag = "R7";
    open_row(2);
    blen = 3'd7;
    burst(3'd3, 14, 20, 16'h7000, 0);
    step(3'd4, 0, 16'hFFFF, 2'b00);
    idle(2);
    cas3 = 1'b0; burst(3'd2, 13, 12, 16'h0, 0);
    step(3'd4, 0, 16'h0, 2'b00); idle(4);
    cas3 = 1'b1; burst(3'd2, 2, 20, 16'h0, 0);
    step(3'd4, 0, 16'h0, 2'b00); idle(5);

    // R8: write masks change every cycle
    tag = "R8";
    blen = 3'd3;
    burst(3'd3, 0, 8, 16'h8181, 32'h0000_E4E4);
    idle(1);
    cas3 = 1'b0; burst(3'd2, 0, 11, 16'h0, 0);

    // R9: read masks change every cycle, both latencies
    tag = "R9";
    burst(3'd2, 0, 12, 16'h0, 32'h001B_39C6);
    cas3 = 1'b1; burst(3'd2, 4, 12, 16'h0, 32'h00C6_1B39);

    // R10: bursts cut short by other commands
    tag = "R10";
    cas3 = 1'b0; blen = 3'd3;
    burst(3'd2, 0, 3, 16'h0, 0);
    burst(3'd2, 9, 11, 16'h0, 0);
    cas3 = 1'b1;
    burst(3'd2, 1, 3, 16'h0, 0);
    burst(3'd3, 6, 9, 16'hA0A0, 0);
    burst(3'd3, 10, 3, 16'hB0B0, 0);
    cas3 = 1'b0; burst(3'd2, 8, 11, 16'h0, 0);
    burst(3'd2, 0, 2, 16'h0, 0);
    open_row(1);
    idle(3);
    burst(3'd2, 4, 11, 16'h0, 0);
    open_row(2);
    burst(3'd2, 8, 10, 16'h0, 0);

    // R2: closing the bank makes later reads and writes void
    tag = "R2";
    step(3'd5, 0, 16'h0, 2'b00);
    burst(3'd3, 0, 3, 16'hDEAD, 0);
    burst(3'd2, 0, 4, 16'h0, 0);
    open_row(2);
    burst(3'd2, 0, 11, 16'h0, 0);
    step(3'd6, 0, 16'h0, 2'b00);
    step(3'd7, 0, 16'h0, 2'b00);
    idle(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule